// File: doc/BRIEF.md
# Source Operand Resolver with Constant Generation

This block works out what the source operand of a 16-bit two-operand or one-operand instruction actually is. The decoder hands it the 4-bit source register number, the 2-bit addressing-mode field and the byte/word bit. The register file hands it the current value of that register, and the fetch stage supplies the extension word that follows the instruction. One clock later the block reports one of three kinds of result:

- a fixed constant;
- the register's own value;
- a memory address that the load path must read.

Alongside the result it reports whether an extension word was consumed, and which register to bump afterwards and by how much.

Three registers are treated specially. The program counter (register 0) turns auto-increment into an immediate fetch and indexed mode into PC-relative addressing. Register 2 supplies a zero base for absolute addressing and the constants 4 and 8. Register 3 never acts as a register: it always supplies one of the constants 0, 1, 2 or all-ones. These constants cost no extension word and never cause a register write-back.

The caller applies the post-increment only after the reported address has been used. The block itself holds no register state beyond its output stage.

Top module: `srcop_resolver`

## Requirements
- R1: With mode 00 and any source register other than 3, the result kind is register value (kind code 1). The value equals `reg_value`, with no extension word, increment amount 0 and increment register 0.
- R2: With mode 01 and a source register other than 2 or 3, including the program counter, the kind is memory address (code 2). The value is `reg_value + ext_word` modulo 2^16, and the extension flag is 1.
- R3: With register 2 and mode 01, the kind is memory address. The value is `ext_word` alone (zero base), and the extension flag is 1.
- R4: With mode 10 and a source register other than 2 or 3, the kind is memory address. The value is `reg_value`, the extension flag is 0 and the increment amount is 0.
- R5: With mode 11 and a source register from 1 to 15 other than 2 and 3, the kind is memory address and the value is `reg_value`. The extension flag is 0, the increment amount is 1 for a byte access (`is_byte`=1) and 2 for a word access, and the increment register is the source register.
- R6: With register 0 and mode 11 (immediate), the kind is memory address and the value is `reg_value`. The extension flag is 1, the increment amount is 2 whatever `is_byte` is, and the increment register is 0.
- R7: With register 2, mode 10 gives a constant (kind code 0) of 4 and mode 11 a constant of 8. Both have extension flag 0 and increment amount 0.
- R8: With register 3, modes 00, 01, 10 and 11 give constants 0x0000, 0x0001, 0x0002 and 0xFFFF. All have extension flag 0, increment amount 0 and increment register 0, and `is_byte` has no effect.
- R9: All outputs are registered. A request accepted with `in_valid`=1 appears on the outputs after the next rising edge, with `out_valid`=1. When `in_valid` is 0, `out_valid` drops after that edge and the other outputs keep their previous values.
- R10: While the synchronous active-high `rst` is sampled high, every output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| src_reg | input | 4 | Source register number |
| src_mode | input | 2 | Source addressing-mode field |
| is_byte | input | 1 | 1 = byte access, 0 = word access |
| reg_value | input | 16 | Current value of the source register |
| ext_word | input | 16 | Extension word following the instruction |
| out_valid | output | 1 | Result present |
| out_kind | output | 2 | 0 constant, 1 register value, 2 memory address |
| out_value | output | 16 | Constant, register value or address |
| out_ext_used | output | 1 | An extension word was consumed |
| out_inc_amt | output | 2 | Post-increment amount (0, 1 or 2) |
| out_inc_reg | output | 4 | Register to post-increment |

## Verification
The assertions assume that the caller presents `reg_value` and `ext_word` in the same cycle as the request, and that `ext_word` is meaningful whenever the mode needs one. They also take no position on the program counter's alignment. The stimulus draws every register number, mode, width bit, register value and extension word from a seeded generator, so both the special registers and arbitrary data are reached. Directed requests cover each constant-generator pair, immediate with byte width, address wrap-around and idle cycles between requests.

// File: rtl/srcop_pkg.sv
package srcop_pkg;
  typedef enum logic [1:0] {
    KIND_CONST = 2'd0,
    KIND_REG   = 2'd1,
    KIND_MEM   = 2'd2
  } srcop_kind_e;

  typedef enum logic [1:0] {
    AM_DIRECT  = 2'd0,
    AM_INDEXED = 2'd1,
    AM_POINTER = 2'd2,
    AM_POSTINC = 2'd3
  } srcop_mode_e;

  localparam logic [1:0] INC_NONE = 2'd0;
  localparam logic [1:0] INC_BYTE = 2'd1;
  localparam logic [1:0] INC_WORD = 2'd2;
endpackage

// File: rtl/srcop_classify.sv
module srcop_classify #(
  parameter int REG_AW = 4,
  parameter int PC_IDX = 0,
  parameter int SR_IDX = 2,
  parameter int CG_IDX = 3
) (
  input  logic [REG_AW-1:0] reg_idx,
  input  logic [1:0]        mode,
  output logic              is_pc,
  output logic              is_sr,
  output logic              use_const,
  output logic              zero_base
);
  localparam logic [REG_AW-1:0] PC_SEL = REG_AW'(PC_IDX);
  localparam logic [REG_AW-1:0] SR_SEL = REG_AW'(SR_IDX);
  localparam logic [REG_AW-1:0] CG_SEL = REG_AW'(CG_IDX);

  logic is_cg;

  always_comb begin
    is_pc     = (reg_idx == PC_SEL);
    is_sr     = (reg_idx == SR_SEL);
    is_cg     = (reg_idx == CG_SEL);
    // constant register always; status register only for the pointer modes
    use_const = is_cg || (is_sr && mode[1]);
    zero_base = is_sr && (mode == 2'd1);
  end
endmodule

// File: rtl/srcop_constgen.sv
module srcop_constgen #(
  parameter int DATA_W = 16
) (
  input  logic              from_sr,
  input  logic [1:0]        mode,
  output logic [DATA_W-1:0] cval
);
  always_comb begin
    if (from_sr) begin
      cval = mode[0] ? DATA_W'(8) : DATA_W'(4);
    end else if (mode == 2'd3) begin
      cval = '1;
    end else begin
      cval = DATA_W'(mode);
    end
  end
endmodule

// File: rtl/srcop_addr.sv
module srcop_addr #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] offset,
  input  logic              zero_base,
  output logic [DATA_W-1:0] addr
);
  logic [DATA_W-1:0] eff_base;

  always_comb begin
    eff_base = zero_base ? '0 : base;
    addr     = eff_base + offset;
  end
endmodule

// File: rtl/srcop_resolver.sv
module srcop_resolver
  import srcop_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_AW = 4,
  parameter int PC_IDX = 0,
  parameter int SR_IDX = 2,
  parameter int CG_IDX = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [REG_AW-1:0] src_reg,
  input  logic [1:0]        src_mode,
  input  logic              is_byte,
  input  logic [DATA_W-1:0] reg_value,
  input  logic [DATA_W-1:0] ext_word,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [DATA_W-1:0] out_value,
  output logic              out_ext_used,
  output logic [1:0]        out_inc_amt,
  output logic [REG_AW-1:0] out_inc_reg
);
  logic              is_pc, is_sr, use_const, zero_base;
  logic [DATA_W-1:0] cval, idx_addr;

  srcop_kind_e       n_kind;
  logic [DATA_W-1:0] n_value;
  logic              n_ext;
  logic [1:0]        n_inc;
  logic [REG_AW-1:0] n_inc_reg;

  srcop_classify #(
    .REG_AW(REG_AW), .PC_IDX(PC_IDX), .SR_IDX(SR_IDX), .CG_IDX(CG_IDX)
  ) u_classify (
    .reg_idx  (src_reg),
    .mode     (src_mode),
    .is_pc    (is_pc),
    .is_sr    (is_sr),
    .use_const(use_const),
    .zero_base(zero_base)
  );

  srcop_constgen #(.DATA_W(DATA_W)) u_constgen (
    .from_sr(is_sr),
    .mode   (src_mode),
    .cval   (cval)
  );

  srcop_addr #(.DATA_W(DATA_W)) u_addr (
    .base     (reg_value),
    .offset   (ext_word),
    .zero_base(zero_base),
    .addr     (idx_addr)
  );

  always_comb begin
    n_kind    = KIND_REG;
    n_value   = reg_value;
    n_ext     = 1'b0;
    n_inc     = INC_NONE;
    n_inc_reg = '0;
    if (use_const) begin
      n_kind  = KIND_CONST;
      n_value = cval;
    end else begin
      unique case (srcop_mode_e'(src_mode))
        AM_DIRECT: ;
        AM_INDEXED: begin
          n_kind  = KIND_MEM;
          n_value = idx_addr;
          n_ext   = 1'b1;
        end
        AM_POINTER: begin
          n_kind = KIND_MEM;
        end
        AM_POSTINC: begin
          n_kind    = KIND_MEM;
          n_ext     = is_pc;
          n_inc     = (is_byte && !is_pc) ? INC_BYTE : INC_WORD;
          n_inc_reg = src_reg;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_kind     <= '0;
      out_value    <= '0;
      out_ext_used <= 1'b0;
      out_inc_amt  <= '0;
      out_inc_reg  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_kind     <= n_kind;
        out_value    <= n_value;
        out_ext_used <= n_ext;
        out_inc_amt  <= n_inc;
        out_inc_reg  <= n_inc_reg;
      end
    end
  end
endmodule

// File: rtl/srcop_resolver_checker.sv
module srcop_resolver_checker #(
  parameter int DATA_W = 16,
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [REG_AW-1:0] src_reg,
  input logic [1:0]        src_mode,
  input logic [DATA_W-1:0] ext_word,
  input logic              out_valid,
  input logic [1:0]        out_kind,
  input logic [DATA_W-1:0] out_value,
  input logic              out_ext_used,
  input logic [1:0]        out_inc_amt
);
  // R9
  p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R7, R8
  p_const_no_inc_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == 2'd0) |-> (out_inc_amt == 2'd0 && !out_ext_used));

  // R8
  p_cg_reg_const_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_reg == REG_AW'(3)) |=> (out_kind == 2'd0));

  // R3
  p_abs_zero_base_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_reg == REG_AW'(2) && src_mode == 2'd1)
      |=> (out_value == $past(ext_word) && out_ext_used));

  // R4
  p_pointer_no_ext_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_mode == 2'd2) |=> (!out_ext_used && out_inc_amt == 2'd0));
endmodule

bind srcop_resolver srcop_resolver_checker #(
  .DATA_W(DATA_W), .REG_AW(REG_AW)
) u_srcop_checker (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .src_reg     (src_reg),
  .src_mode    (src_mode),
  .ext_word    (ext_word),
  .out_valid   (out_valid),
  .out_kind    (out_kind),
  .out_value   (out_value),
  .out_ext_used(out_ext_used),
  .out_inc_amt (out_inc_amt)
);

// File: tb/test_srcop_resolver.sv
`timescale 1ns/1ps
module test_srcop_resolver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  src_reg = '0;
  logic [1:0]  src_mode = '0;
  logic        is_byte = 1'b0;
  logic [15:0] reg_value = '0;
  logic [15:0] ext_word = '0;
  logic        out_valid;
  logic [1:0]  out_kind;
  logic [15:0] out_value;
  logic        out_ext_used;
  logic [1:0]  out_inc_amt;
  logic [3:0]  out_inc_reg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  srcop_resolver i_srcop_resolver (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_reg(src_reg),
    .src_mode(src_mode), .is_byte(is_byte), .reg_value(reg_value),
    .ext_word(ext_word), .out_valid(out_valid), .out_kind(out_kind),
    .out_value(out_value), .out_ext_used(out_ext_used),
    .out_inc_amt(out_inc_amt), .out_inc_reg(out_inc_reg)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] value;
    logic        ext;
    logic [1:0]  inc;
    logic [3:0]  ireg;
  } exp_t;

  function automatic exp_t model(input logic [3:0] r, input logic [1:0] m,
                                 input logic b, input logic [15:0] rv,
                                 input logic [15:0] ew);
    exp_t e;
    e = '{kind: 2'd1, value: rv, ext: 1'b0, inc: 2'd0, ireg: 4'd0};
    if (r == 4'd3) begin
      e.kind  = 2'd0;
      e.value = (m == 2'd0) ? 16'h0000 : (m == 2'd1) ? 16'h0001 :
                (m == 2'd2) ? 16'h0002 : 16'hFFFF;
    end else if (r == 4'd2 && m[1]) begin
      e.kind  = 2'd0;
      e.value = m[0] ? 16'd8 : 16'd4;
    end else if (m == 2'd1) begin
      e.kind  = 2'd2;
      e.value = (r == 4'd2) ? ew : rv + ew;
      e.ext   = 1'b1;
    end else if (m == 2'd2) begin
      e.kind = 2'd2;
    end else if (m == 2'd3) begin
      e.kind = 2'd2;
      e.ireg = r;
      if (r == 4'd0) begin
        e.ext = 1'b1;
        e.inc = 2'd2;
      end else begin
        e.inc = b ? 2'd1 : 2'd2;
      end
    end
    return e;
  endfunction

  function automatic string req_of(input logic [3:0] r, input logic [1:0] m);
    if (r == 4'd3) return "R8";
    if (r == 4'd2 && m[1]) return "R7";
    if (r == 4'd2 && m == 2'd1) return "R3";
    if (m == 2'd0) return "R1";
    if (m == 2'd1) return "R2";
    if (m == 2'd2) return "R4";
    if (r == 4'd0) return "R6";
    return "R5";
  endfunction

  task automatic check(input string req, input exp_t act, input exp_t exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act kind=%0d val=%h ext=%0b inc=%0d reg=%0d exp kind=%0d val=%h ext=%0b inc=%0d reg=%0d",
               req, act.kind, act.value, act.ext, act.inc, act.ireg,
               exp.kind, exp.value, exp.ext, exp.inc, exp.ireg);
    end
  endtask

  function automatic exp_t observed();
    return '{kind: out_kind, value: out_value, ext: out_ext_used,
             inc: out_inc_amt, ireg: out_inc_reg};
  endfunction

  task automatic apply(input logic [3:0] r, input logic [1:0] m, input logic b,
                       input logic [15:0] rv, input logic [15:0] ew);
    @(negedge clk);
    in_valid = 1'b1; src_reg = r; src_mode = m; is_byte = b;
    reg_value = rv; ext_word = ew;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R9 act out_valid=%0b exp 1", out_valid);
    end
    check(req_of(r, m), observed(), model(r, m, b, rv, ew));
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act running exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10: reset clears outputs
    check("R10", observed(), '0);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10 act out_valid=%0b exp 0", out_valid);
    end
    rst = 1'b0;

    // R8: every constant pair, byte flag irrelevant
    for (int m = 0; m < 4; m++) begin
      apply(4'd3, 2'(m), 1'b0, 16'h1234, 16'h5678);
      apply(4'd3, 2'(m), 1'b1, 16'hABCD, 16'h0F0F);
    end
    // R7
    apply(4'd2, 2'd2, 1'b0, 16'hFFFF, 16'h1111);
    apply(4'd2, 2'd3, 1'b1, 16'hFFFF, 16'h1111);
    // R3
    apply(4'd2, 2'd1, 1'b0, 16'h8000, 16'h0200);
    // R1 register mode on SR and PC
    apply(4'd2, 2'd0, 1'b0, 16'h0107, 16'h0000);
    apply(4'd0, 2'd0, 1'b0, 16'hC000, 16'h0000);
    // R2 wrap-around and PC-relative
    apply(4'd9, 2'd1, 1'b0, 16'hFFF0, 16'h0020);
    apply(4'd0, 2'd1, 1'b0, 16'hE002, 16'hFFFE);
    // R4
    apply(4'd5, 2'd2, 1'b1, 16'h0300, 16'h4444);
    // R5 byte and word, stack pointer
    apply(4'd5, 2'd3, 1'b1, 16'h0300, 16'h0000);
    apply(4'd15, 2'd3, 1'b0, 16'h0400, 16'h0000);
    apply(4'd1, 2'd3, 1'b1, 16'h0A00, 16'h0000);
    // R6 immediate with byte width still advances by two
    apply(4'd0, 2'd3, 1'b1, 16'hF010, 16'h0064);
    apply(4'd0, 2'd3, 1'b0, 16'hF020, 16'h0064);

    // R9: idle cycle drops valid and holds data
    held = observed();
    @(negedge clk);
    in_valid = 1'b0; src_reg = 4'd7; src_mode = 2'd1; reg_value = 16'h5555;
    ext_word = 16'h3333;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9 act out_valid=%0b exp 0", out_valid);
    end
    check("R9", observed(), held);

    // random mix
    for (int i = 0; i < 600; i++) begin
      apply(4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom));
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end

    // R10: reset mid-stream
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    check("R10", observed(), '0);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10 act out_valid=%0b exp 0", out_valid);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule